// File: doc/BRIEF.md
# Bus Hand-Over Controller for an External DMA Master

This block lets an external master borrow the external memory bus of a CPU. The master pulls a shared input pin low to ask for the bus. The controller passes that pin through a synchronizer and lets any CPU bus cycle in progress run to its end. It then stops driving address, data, read, write and chip-enable, and pulls a shared output pin low as the grant. While the bus is lent out, the CPU's bus interface is held by a stall signal. Internal-memory selects are forced inactive, so the master can only reach external devices. When the master lets the request pin go high, the grant rises first. One clock later the CPU drives the bus again.

A software-written enable bit chooses what the two pins are used for. With the bit clear, the input pin is an ordinary input port bit, the output pin carries a software-written port value, and requests are ignored. The pads are outside the block, so high impedance is shown by output-enable signals (active high) next to each driven bus value. While the bus is lent out, a phase output alternates every clock and marks the two-step idle rhythm.

Top module: `busrel_ctrl`

## Requirements
- R1: After reset, the enable bit is clear, `pin_ack_o` equals `port_out_i`, `bus_oe_o` is 1, `cpu_stall_o` is 0 and `imem_sel_o` follows `imem_sel_i`.
- R2: With enable set and `cpu_cyc_done_i` high, a low level on `pin_req_i` that is driven just after clock edge N gives `bus_oe_o`=0 after edge N+3, with `pin_ack_o` still 1. `pin_ack_o` goes to 0 after edge N+4. Two of those clocks are the synchronizer.
- R3: While `cpu_cyc_done_i` is 0, a pending request leaves the bus driven and the stall low. The outputs float on the clock edge after `cpu_cyc_done_i` is seen high.
- R4: With enable clear and no release in progress, `pin_ack_o` equals `port_out_i` and a low request changes neither `bus_oe_o` nor `cpu_stall_o`. `port_in_o` always shows `pin_req_i` delayed by the two synchronizer clocks. Writing `cfg_en_i` with `cfg_we_i` high takes effect at the next edge.
- R5: Whenever `bus_oe_o` is 0, `bus_data_oe_o` and `imem_sel_o` are 0. Once the bus is driven again, `imem_sel_o` follows `imem_sel_i`.
- R6: When the request pin returns high, `pin_ack_o` rises 3 edges later while `bus_oe_o` stays 0. `bus_oe_o` returns to 1 one edge after that.
- R7: `cpu_stall_o` is 1 in every cycle in which `bus_oe_o` is 0, and 0 once the bus is driven again.
- R8: While acknowledge is low, `rel_phase_o` starts at 0 and inverts on every clock.
- R9: A request withdrawn before acknowledge has gone low never produces a low acknowledge, and the bus is driven again. If it is withdrawn while waiting for the cycle boundary, the stall never rises.
- R10: Clearing the enable bit during a release keeps the acknowledge function on the output pin until the bus has been handed back. After that the pin reverts to the port value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the enable bit |
| cfg_en_i | input | 1 | Enable value to write (1 = request/acknowledge function) |
| pin_req_i | input | 1 | Shared input pin: request (active low) or port input |
| pin_ack_o | output | 1 | Shared output pin: acknowledge (active low) or port output |
| port_in_o | output | 1 | Synchronized value of the shared input pin |
| port_out_i | input | 1 | Port value for the shared output pin |
| cpu_cyc_done_i | input | 1 | CPU bus interface is at a cycle boundary this clock |
| cpu_stall_o | output | 1 | Holds the CPU's next bus cycle |
| cpu_addr_i | input | ADDR_W | CPU address |
| cpu_wdata_i | input | DATA_W | CPU write data |
| cpu_dout_en_i | input | 1 | CPU wants to drive the data bus |
| cpu_rd_n_i | input | 1 | CPU read strobe, active low |
| cpu_wr_n_i | input | 1 | CPU write strobe, active low |
| cpu_ce_n_i | input | CE_W | CPU chip enables, active low |
| imem_sel_i | input | 1 | CPU's internal-memory select |
| imem_sel_o | output | 1 | Gated internal-memory select |
| bus_addr_o | output | ADDR_W | External address value |
| bus_data_o | output | DATA_W | External data value |
| bus_rd_n_o | output | 1 | External read strobe |
| bus_wr_n_o | output | 1 | External write strobe |
| bus_ce_n_o | output | CE_W | External chip enables |
| bus_oe_o | output | 1 | Drive enable for address, strobes and chip enables |
| bus_data_oe_o | output | 1 | Drive enable for the data bus |
| rel_phase_o | output | 1 | Idle phase during the release |

## Verification
The bench goes after the hand-over edges. A design that raised acknowledge before floating the bus, or drove the bus again in the same clock that acknowledge rose, would fail the cycle-exact checks on both sides of the release. Requests are withdrawn at two points: while the controller waits for a CPU cycle to end, and in the single clock after the outputs float. A controller without a clean abort would pulse acknowledge low or leave the stall stuck. The bench also clears the enable bit in the middle of a release and sends a request in port mode. A design that dropped the grant early, or that acted on requests while disabled, would float the bus or show the wrong pin value.

// File: rtl/busrel_pkg.sv
package busrel_pkg;

    typedef enum logic [2:0] {
        ST_OWN   = 3'd0,
        ST_WAIT  = 3'd1,
        ST_FLOAT = 3'd2,
        ST_REL   = 3'd3,
        ST_RET   = 3'd4
    } brl_state_e;

    typedef struct packed {
        brl_state_e state;
        logic       phase;
        logic       en;
    } brl_regs_t;

endpackage

// File: rtl/busrel_sync.sv
module busrel_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign sh_d[g] = d_i;
        end else begin : g_next
            assign sh_d[g] = sh_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= {STAGES{RST_VAL}};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/busrel_fsm.sv
module busrel_fsm
    import busrel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we_i,
    input  logic cfg_en_i,
    input  logic req_n_i,
    input  logic cyc_done_i,
    output logic ack_n_o,
    output logic bus_own_o,
    output logic stall_o,
    output logic phase_o,
    output logic func_o
);
    brl_regs_t r_d;
    brl_regs_t r_q;

    always_comb begin
        r_d       = r_q;
        r_d.phase = 1'b0;
        if (cfg_we_i) begin
            r_d.en = cfg_en_i;
        end
        unique case (r_q.state)
            ST_OWN: begin
                if (r_q.en && !req_n_i) begin
                    r_d.state = cyc_done_i ? ST_FLOAT : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (req_n_i) begin
                    r_d.state = ST_OWN;
                end else if (cyc_done_i) begin
                    r_d.state = ST_FLOAT;
                end
            end
            ST_FLOAT: begin
                r_d.state = req_n_i ? ST_OWN : ST_REL;
            end
            ST_REL: begin
                if (req_n_i) begin
                    r_d.state = ST_RET;
                end else begin
                    r_d.phase = ~r_q.phase;
                end
            end
            ST_RET: begin
                r_d.state = ST_OWN;
            end
            default: begin
                r_d.state = ST_OWN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_OWN, phase: 1'b0, en: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_n_o   = (r_q.state != ST_REL);
    assign bus_own_o = (r_q.state == ST_OWN) || (r_q.state == ST_WAIT);
    assign stall_o   = (r_q.state == ST_FLOAT) || (r_q.state == ST_REL) ||
                       (r_q.state == ST_RET);
    assign phase_o   = r_q.phase;
    assign func_o    = r_q.en || (r_q.state != ST_OWN);
endmodule

// File: rtl/busrel_pinmux.sv
module busrel_pinmux #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int CE_W   = 4,
    parameter logic [CE_W-1:0] CE_IDLE = '1
) (
    input  logic              bus_own_i,
    input  logic              func_i,
    input  logic              ack_n_i,
    input  logic              port_out_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    input  logic              cpu_dout_en_i,
    input  logic              cpu_rd_n_i,
    input  logic              cpu_wr_n_i,
    input  logic [CE_W-1:0]   cpu_ce_n_i,
    input  logic              imem_sel_i,
    output logic              pin_ack_o,
    output logic              imem_sel_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_rd_n_o,
    output logic              bus_wr_n_o,
    output logic [CE_W-1:0]   bus_ce_n_o,
    output logic              bus_oe_o,
    output logic              bus_data_oe_o
);
    always_comb begin
        pin_ack_o     = func_i ? ack_n_i : port_out_i;
        bus_oe_o      = bus_own_i;
        bus_data_oe_o = bus_own_i && cpu_dout_en_i;
        imem_sel_o    = bus_own_i && imem_sel_i;
        if (bus_own_i) begin
            bus_addr_o = cpu_addr_i;
            bus_data_o = cpu_wdata_i;
            bus_rd_n_o = cpu_rd_n_i;
            bus_wr_n_o = cpu_wr_n_i;
            bus_ce_n_o = cpu_ce_n_i;
        end else begin
            bus_addr_o = '0;
            bus_data_o = '0;
            bus_rd_n_o = 1'b1;
            bus_wr_n_o = 1'b1;
            bus_ce_n_o = CE_IDLE;
        end
    end
endmodule

// File: rtl/busrel_ctrl.sv
module busrel_ctrl #(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 8,
    parameter int CE_W        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic              cfg_en_i,
    input  logic              pin_req_i,
    output logic              pin_ack_o,
    output logic              port_in_o,
    input  logic              port_out_i,
    input  logic              cpu_cyc_done_i,
    output logic              cpu_stall_o,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    input  logic              cpu_dout_en_i,
    input  logic              cpu_rd_n_i,
    input  logic              cpu_wr_n_i,
    input  logic [CE_W-1:0]   cpu_ce_n_i,
    input  logic              imem_sel_i,
    output logic              imem_sel_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_rd_n_o,
    output logic              bus_wr_n_o,
    output logic [CE_W-1:0]   bus_ce_n_o,
    output logic              bus_oe_o,
    output logic              bus_data_oe_o,
    output logic              rel_phase_o
);
    localparam logic [CE_W-1:0] CE_IDLE = {CE_W{1'b1}};
    localparam int SYNC_N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic req_sync_n;
    logic ack_n;
    logic bus_own;
    logic func;

    busrel_sync #(
        .STAGES (SYNC_N),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (pin_req_i),
        .q_o  (req_sync_n)
    );

    busrel_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we_i  (cfg_we_i),
        .cfg_en_i  (cfg_en_i),
        .req_n_i   (req_sync_n),
        .cyc_done_i(cpu_cyc_done_i),
        .ack_n_o   (ack_n),
        .bus_own_o (bus_own),
        .stall_o   (cpu_stall_o),
        .phase_o   (rel_phase_o),
        .func_o    (func)
    );

    busrel_pinmux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CE_W   (CE_W),
        .CE_IDLE(CE_IDLE)
    ) u_pinmux (
        .bus_own_i    (bus_own),
        .func_i       (func),
        .ack_n_i      (ack_n),
        .port_out_i   (port_out_i),
        .cpu_addr_i   (cpu_addr_i),
        .cpu_wdata_i  (cpu_wdata_i),
        .cpu_dout_en_i(cpu_dout_en_i),
        .cpu_rd_n_i   (cpu_rd_n_i),
        .cpu_wr_n_i   (cpu_wr_n_i),
        .cpu_ce_n_i   (cpu_ce_n_i),
        .imem_sel_i   (imem_sel_i),
        .pin_ack_o    (pin_ack_o),
        .imem_sel_o   (imem_sel_o),
        .bus_addr_o   (bus_addr_o),
        .bus_data_o   (bus_data_o),
        .bus_rd_n_o   (bus_rd_n_o),
        .bus_wr_n_o   (bus_wr_n_o),
        .bus_ce_n_o   (bus_ce_n_o),
        .bus_oe_o     (bus_oe_o),
        .bus_data_oe_o(bus_data_oe_o)
    );

    assign port_in_o = req_sync_n;
endmodule

// File: rtl/busrel_ctrl_chk.sv
module busrel_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ack_n,
    input logic bus_oe,
    input logic data_oe,
    input logic stall,
    input logic imem,
    input logic phase
);
    // R2: the bus was already floated in the clock before acknowledge fell
    p_float_before_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> ($past(!bus_oe) && !bus_oe));

    // R6: no CPU drive while the master holds the grant
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !bus_oe);

    // R6: the grant rises while the bus is still floated
    p_return_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_n) |-> !bus_oe);

    // R5: internal memory hidden whenever the bus is lent out
    p_isolation_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (!imem && !data_oe));

    // R7: CPU held whenever it does not drive the bus
    p_stall_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> stall);

    // R8: idle phase alternates during the release
    p_phase_alt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && $past(!ack_n)) |-> (phase != $past(phase)));
endmodule

bind busrel_ctrl busrel_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack_n  (ack_n),
    .bus_oe (bus_oe_o),
    .data_oe(bus_data_oe_o),
    .stall  (cpu_stall_o),
    .imem   (imem_sel_o),
    .phase  (rel_phase_o)
);

// File: tb/busrel_ctrl_bench.sv
module busrel_ctrl_bench;
    localparam int AW = 20;
    localparam int DW = 8;
    localparam int CW = 4;

    typedef enum int {S_OE, S_ACK, S_STALL, S_DOE, S_IMEM, S_PHASE, S_PIN_IN} sig_e;
    typedef struct {
        int    cyc;
        sig_e  sig;
        logic  val;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_en = 1'b0;
    logic pin_req = 1'b1, port_out = 1'b0;
    logic cyc_done = 1'b1, dout_en = 1'b1, imem_in = 1'b1;
    logic pin_ack, port_in, stall, imem_out;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic bus_rd_n, bus_wr_n, bus_oe, bus_doe, phase;
    logic [CW-1:0] bus_ce_n;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;
    exp_t exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    busrel_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CE_W(CW), .SYNC_STAGES(2)) u_busrel_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en),
        .pin_req_i(pin_req), .pin_ack_o(pin_ack), .port_in_o(port_in),
        .port_out_i(port_out), .cpu_cyc_done_i(cyc_done), .cpu_stall_o(stall),
        .cpu_addr_i(20'h5A5A5), .cpu_wdata_i(8'hC3), .cpu_dout_en_i(dout_en),
        .cpu_rd_n_i(1'b1), .cpu_wr_n_i(1'b0), .cpu_ce_n_i(4'b1110),
        .imem_sel_i(imem_in), .imem_sel_o(imem_out), .bus_addr_o(bus_addr),
        .bus_data_o(bus_data), .bus_rd_n_o(bus_rd_n), .bus_wr_n_o(bus_wr_n),
        .bus_ce_n_o(bus_ce_n), .bus_oe_o(bus_oe), .bus_data_oe_o(bus_doe),
        .rel_phase_o(phase)
    );

    function automatic logic sample(sig_e s);
        case (s)
            S_OE:    return bus_oe;
            S_ACK:   return pin_ack;
            S_STALL: return stall;
            S_DOE:   return bus_doe;
            S_IMEM:  return imem_out;
            S_PHASE: return phase;
            default: return port_in;
        endcase
    endfunction

    // driver side: queue an expected value d clock edges ahead
    function automatic void expect_at(int d, sig_e s, logic v, string tag);
        exp_t it;
        int pos;
        it.cyc = cyc + d;
        it.sig = s;
        it.val = v;
        it.tag = tag;
        pos = exp_q.size();
        for (int i = 0; i < exp_q.size(); i++) begin
            if (exp_q[i].cyc > it.cyc) begin
                pos = i;
                break;
            end
        end
        exp_q.insert(pos, it);
    endfunction

    // monitor: pop and compare items due in this cycle
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            exp_t it;
            logic act;
            it = exp_q.pop_front();
            act = sample(it.sig);
            n_chk++;
            if (it.cyc != cyc || act !== it.val) begin
                n_fail++;
                $display("FAIL %s: %s at cycle %0d actual=%b expected=%b",
                         it.tag, it.sig.name(), it.cyc, act, it.val);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_at(1, S_OE, 1'b1, "R1");
        expect_at(1, S_ACK, 1'b0, "R1");
        expect_at(1, S_STALL, 1'b0, "R1");
        expect_at(1, S_IMEM, 1'b1, "R1");
        step(3);

        // R4 port mode: request ignored, pins are ports
        pin_req = 1'b0;
        expect_at(1, S_PIN_IN, 1'b1, "R4");
        expect_at(2, S_PIN_IN, 1'b0, "R4");
        expect_at(4, S_OE, 1'b1, "R4");
        expect_at(4, S_STALL, 1'b0, "R4");
        expect_at(4, S_ACK, 1'b0, "R4");
        step(5);
        port_out = 1'b1;
        expect_at(1, S_ACK, 1'b1, "R4");
        step(2);
        port_out = 1'b0;
        pin_req = 1'b1;
        step(4);
        cfg_we = 1'b1;
        cfg_en = 1'b1;
        step(1);
        cfg_we = 1'b0;
        expect_at(1, S_ACK, 1'b1, "R4");
        step(2);

        // R2/R5/R7/R8 release, then R6 return
        pin_req = 1'b0;
        expect_at(2, S_OE, 1'b1, "R2");
        expect_at(3, S_OE, 1'b0, "R2");
        expect_at(3, S_ACK, 1'b1, "R2");
        expect_at(3, S_STALL, 1'b1, "R7");
        expect_at(3, S_DOE, 1'b0, "R5");
        expect_at(3, S_IMEM, 1'b0, "R5");
        expect_at(4, S_ACK, 1'b0, "R2");
        expect_at(4, S_PHASE, 1'b0, "R8");
        expect_at(5, S_PHASE, 1'b1, "R8");
        expect_at(6, S_PHASE, 1'b0, "R8");
        expect_at(7, S_OE, 1'b0, "R5");
        step(8);
        pin_req = 1'b1;
        expect_at(2, S_ACK, 1'b0, "R6");
        expect_at(3, S_ACK, 1'b1, "R6");
        expect_at(3, S_OE, 1'b0, "R6");
        expect_at(3, S_STALL, 1'b1, "R7");
        expect_at(4, S_OE, 1'b1, "R6");
        expect_at(4, S_STALL, 1'b0, "R7");
        expect_at(4, S_IMEM, 1'b1, "R5");
        step(6);

        // R3 wait for the cycle boundary
        cyc_done = 1'b0;
        pin_req = 1'b0;
        expect_at(3, S_OE, 1'b1, "R3");
        expect_at(4, S_STALL, 1'b0, "R3");
        expect_at(5, S_OE, 1'b1, "R3");
        step(5);
        cyc_done = 1'b1;
        expect_at(1, S_OE, 1'b0, "R3");
        expect_at(2, S_ACK, 1'b0, "R3");
        step(4);
        pin_req = 1'b1;
        expect_at(4, S_OE, 1'b1, "R6");
        step(6);

        // R9 abort while waiting for the cycle end
        cyc_done = 1'b0;
        pin_req = 1'b0;
        expect_at(5, S_STALL, 1'b0, "R9");
        expect_at(5, S_OE, 1'b1, "R9");
        step(4);
        pin_req = 1'b1;
        step(5);
        cyc_done = 1'b1;
        expect_at(1, S_OE, 1'b1, "R9");
        expect_at(3, S_ACK, 1'b1, "R9");
        expect_at(3, S_STALL, 1'b0, "R9");
        step(4);

        // R9 abort in the floated clock
        pin_req = 1'b0;
        step(1);
        pin_req = 1'b1;
        expect_at(2, S_OE, 1'b0, "R9");
        expect_at(2, S_ACK, 1'b1, "R9");
        expect_at(3, S_OE, 1'b1, "R9");
        expect_at(3, S_ACK, 1'b1, "R9");
        expect_at(3, S_STALL, 1'b0, "R9");
        expect_at(4, S_ACK, 1'b1, "R9");
        step(6);

        // R10 enable cleared during a release
        port_out = 1'b1;
        pin_req = 1'b0;
        expect_at(4, S_ACK, 1'b0, "R10");
        step(5);
        cfg_we = 1'b1;
        cfg_en = 1'b0;
        step(1);
        cfg_we = 1'b0;
        expect_at(1, S_ACK, 1'b0, "R10");
        expect_at(2, S_OE, 1'b0, "R10");
        step(3);
        pin_req = 1'b1;
        expect_at(3, S_ACK, 1'b1, "R10");
        expect_at(4, S_OE, 1'b1, "R10");
        expect_at(5, S_ACK, 1'b1, "R4");
        step(6);
        port_out = 1'b0;
        expect_at(1, S_ACK, 1'b0, "R4");
        step(2);
        pin_req = 1'b0;
        expect_at(4, S_OE, 1'b1, "R4");
        expect_at(5, S_STALL, 1'b0, "R4");
        expect_at(6, S_OE, 1'b1, "R4");
        step(8);
        pin_req = 1'b1;
        step(4);

        while (exp_q.size() > 0) step(1);
        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule